// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer Counter

This block is a single up/down counter whose advance is paced by a clock-enable tick from a power-of-two prescaler. A 2-bit mode field selects one of four count sequences:

- **Free-running:** wraps through the full range.
- **One-shot down count:** reloads from a terminal value.
- **Modulo count:** returns to zero after the terminal value.
- **Symmetric up/down count:** turns around at the terminal value, which suits center-aligned PWM.

Each completed sequence raises a terminal-count event. That event sets a sticky overflow flag, which drives an interrupt request through a mask bit.

Software controls the block with four inputs: a run level, a clear strobe, a flag-clear pulse and the terminal value. Typically it picks a mode and a divide value, loads the terminal value, raises the run level, and then services the interrupt request. The current count and the count direction are always visible at the ports.

Top module: `modal_timer8`

## Requirements
- R1: While `run_en` stays 1, the counter takes one step every 2^`div_sel` clock cycles. The prescaler restarts from zero on a clear strobe and on the rising edge of `run_en`. No step occurs in the cycle of that rising edge.
- R2: While `run_en` is 0, the count and direction hold their present values and are not cleared.
- R3: In free-running mode (`mode_sel`=0), each step adds one and 0xFF wraps to 0x00. The step that makes the count 0xFF is a terminal-count event.
- R4: In down mode (`mode_sel`=1), a rising edge of `run_en` loads `limit_val` and sets `count_down`. Each step subtracts one. The step from 0x01 to 0x00 is a terminal-count event. At 0x00 the count stays at 0x00 until the next load.
- R5: In modulo mode (`mode_sel`=2), each step adds one until the count is at or above `limit_val`. The next step then returns the count to 0x00 and is a terminal-count event.
- R6: In up/down mode (`mode_sel`=3), the count rises to `limit_val`, then falls with `count_down`=1. The step that brings it back to 0x00 is a terminal-count event and restores the up direction.
- R7: A clear strobe forces the count to 0x00 and `count_down` to 0. This has priority over every other count action.
- R8: A terminal-count event sets `ovf_flag` and raises `tc_pulse` for one cycle, in the same cycle the new count appears. `ovf_flag` stays set until an `ovf_clr` pulse. An event and a clear in the same cycle leave the flag set.
- R9: `irq` is 1 exactly while `ovf_flag` and `ovf_mask` are both 1. This includes the case where the mask is raised after the flag is already set.
- R10: After reset the count, direction, `tc_pulse`, `ovf_flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counting enable level; its rising edge restarts the prescaler and, in down mode, loads |
| clr_stb | input | 1 | Clear strobe: count to zero, direction to up |
| mode_sel | input | 2 | 0 free, 1 down, 2 modulo, 3 up/down |
| div_sel | input | 3 | Prescale exponent: one step per 2^div_sel cycles |
| limit_val | input | 8 | Terminal value for the down, modulo and up/down modes |
| ovf_mask | input | 1 | Interrupt enable for the overflow flag |
| ovf_clr | input | 1 | Pulse that clears the overflow flag |
| count | output | 8 | Current count |
| count_down | output | 1 | 1 while counting downward |
| tc_pulse | output | 1 | One-cycle terminal-count event |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default widths: an 8-bit count and a 3-bit divide field, which give a 7-bit prescaler. This keeps a full free-running wrap to 256 cycles, so the 0xFF event and its wrap both fall inside a short run. Random terminal values are drawn mostly from a small range, so that modulo, down and up/down turnarounds happen often, including limits of 0 and 1. Divide settings span the whole range up to 128, which covers every mask width of the prescaler.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_MOD  = 2'd2,
        MODE_UPDN = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/tcnt_prescale.sv
module tcnt_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W-1:0] mask;

    // mask has div_sel low ones; an exponent of PRE_W wraps to all ones
    always_comb begin
        one_hot = (PRE_W + 1)'(1) << div_sel;
        mask    = one_hot[PRE_W-1:0] - PRE_W'(1);
        tick    = run & ~restart & ((pre_q & mask) == mask);
        pre_d   = pre_q;
        if (restart) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R1
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    // R1
    div_two_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel == DIV_W'(1)) |=> !(tick && div_sel == DIV_W'(1)));

endmodule

// File: rtl/tcnt_core.sv
module tcnt_core
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] limit,
    output logic             start_edge,
    output logic             term_evt,
    output logic [CNT_W-1:0] count,
    output logic             count_down,
    output logic             tc_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             tc;
        logic             run;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] inc_v, dec_v;
    logic             turn;
    logic             evt;

    always_comb begin
        st_d       = st_q;
        st_d.run   = run;
        evt        = 1'b0;
        turn       = 1'b0;
        start_edge = run & ~st_q.run;
        inc_v      = st_q.cnt + CNT_ONE;
        dec_v      = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_ONE;
        if (clr) begin
            st_d.cnt = '0;
            st_d.dir = 1'b0;
        end else if (start_edge) begin
            if (mode == MODE_DOWN) begin
                st_d.cnt = limit;
                st_d.dir = 1'b1;
            end
        end else if (tick) begin
            unique case (mode)
                MODE_FREE: begin
                    st_d.dir = 1'b0;
                    st_d.cnt = inc_v;
                    evt      = (inc_v == CNT_MAX);
                end
                MODE_DOWN: begin
                    st_d.dir = 1'b1;
                    st_d.cnt = dec_v;
                    evt      = (st_q.cnt == CNT_ONE);
                end
                MODE_MOD: begin
                    st_d.dir = 1'b0;
                    if (st_q.cnt >= limit) begin
                        st_d.cnt = '0;
                        evt      = 1'b1;
                    end else begin
                        st_d.cnt = inc_v;
                    end
                end
                MODE_UPDN: begin
                    turn = ~st_q.dir & (st_q.cnt >= limit);
                    if (st_q.dir | turn) begin
                        st_d.cnt = dec_v;
                        st_d.dir = 1'b1;
                        if (dec_v == '0) begin
                            st_d.dir = 1'b0;
                            evt      = 1'b1;
                        end
                    end else begin
                        st_d.cnt = inc_v;
                        st_d.dir = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        st_d.tc  = evt;
        term_evt = evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count      = st_q.cnt;
    assign count_down = st_q.dir;
    assign tc_pulse   = st_q.tc;

    // R7
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !count_down));

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(count) && $stable(count_down)));

    // R4
    down_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN && count == '0 && !clr && !start_edge) |=> (count == '0 && !tc_pulse));

    // R5
    modulo_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MOD && tick && !clr && count >= limit) |=> (count == '0 && tc_pulse));

endmodule

// File: rtl/tcnt_flag.sv
module tcnt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    input  logic mask,
    output logic flag,
    output logic irq
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = set_evt | (flag_q & ~clr_req);
        irq    = flag_q & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

    // R8
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !flag);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

endmodule

// File: rtl/modal_timer8.sv
module modal_timer8
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             clr_stb,
    input  logic [1:0]       mode_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [CNT_W-1:0] limit_val,
    input  logic             ovf_mask,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             count_down,
    output logic             tc_pulse,
    output logic             ovf_flag,
    output logic             irq
);
    logic      tick;
    logic      start_edge;
    logic      term_evt;
    logic      pre_restart;
    cnt_mode_e mode;

    assign mode        = cnt_mode_e'(mode_sel);
    assign pre_restart = clr_stb | start_edge;

    tcnt_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_en),
        .restart (pre_restart),
        .div_sel (div_sel),
        .tick    (tick)
    );

    tcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_en),
        .clr        (clr_stb),
        .tick       (tick),
        .mode       (mode),
        .limit      (limit_val),
        .start_edge (start_edge),
        .term_evt   (term_evt),
        .count      (count),
        .count_down (count_down),
        .tc_pulse   (tc_pulse)
    );

    tcnt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (term_evt),
        .clr_req (ovf_clr),
        .mask    (ovf_mask),
        .flag    (ovf_flag),
        .irq     (irq)
    );

endmodule

// File: tb/modal_timer8_bench.sv
module modal_timer8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       clr_stb = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [2:0] div_sel = 3'd0;
    logic [7:0] limit_val = 8'd0;
    logic       ovf_mask = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] count;
    logic       count_down, tc_pulse, ovf_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    // model state
    int    m_pre = 0;
    int    m_cnt = 0;
    int    m_dir = 0;
    int    m_tc = 0;
    int    m_flag = 0;
    int    m_run = 0;
    string m_tag = "R10";

    always #2 clk = ~clk;

    modal_timer8 u_modal_timer8 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_stb(clr_stb),
        .mode_sel(mode_sel), .div_sel(div_sel), .limit_val(limit_val),
        .ovf_mask(ovf_mask), .ovf_clr(ovf_clr), .count(count),
        .count_down(count_down), .tc_pulse(tc_pulse), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(int md);
        case (md)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // reference model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_dir = 0; m_tc = 0; m_flag = 0; m_run = 0;
        end else begin
            int run_i, md, lim, msk, nxt, evt;
            bit start, tk;
            run_i = int'(run_en);
            md    = int'(mode_sel);
            lim   = int'(limit_val);
            msk   = (1 << div_sel) - 1;
            start = (run_i == 1) && (m_run == 0);
            evt   = 0;
            m_tag = mode_tag(md);
            if (clr_stb) begin
                m_cnt = 0; m_dir = 0; m_pre = 0; m_tag = "R7";
            end else if (start) begin
                m_pre = 0;
                if (md == 1) begin m_cnt = lim; m_dir = 1; end
            end else if (run_i == 1) begin
                tk    = ((m_pre & msk) == msk);
                m_pre = (m_pre + 1) & 127;
                if (tk) begin
                    case (md)
                        0: begin m_dir = 0; m_cnt = (m_cnt + 1) & 255; evt = (m_cnt == 255); end
                        1: begin m_dir = 1; if (m_cnt != 0) begin evt = (m_cnt == 1); m_cnt--; end end
                        2: begin m_dir = 0; if (m_cnt >= lim) begin m_cnt = 0; evt = 1; end else m_cnt++; end
                        default: begin
                            if (m_dir == 0 && m_cnt < lim) begin
                                m_cnt++;
                            end else begin
                                nxt = (m_cnt == 0) ? 0 : m_cnt - 1;
                                m_cnt = nxt; m_dir = 1;
                                if (nxt == 0) begin m_dir = 0; evt = 1; end
                            end
                        end
                    endcase
                end
            end
            m_run  = run_i;
            m_tc   = evt;
            m_flag = (evt != 0 || (m_flag != 0 && !ovf_clr)) ? 1 : 0;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(m_tag, "count", int'(count), m_cnt);
            chk(m_tag, "count_down", int'(count_down), m_dir);
            chk(m_tag, "tc_pulse(R8)", int'(tc_pulse), m_tc);
            chk("R8", "ovf_flag", int'(ovf_flag), m_flag);
            chk("R9", "irq", int'(irq), m_flag & int'(ovf_mask));
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0c8a));
        step(3);
        // R10 reset state
        chk("R10", "count", int'(count), 0);
        chk("R10", "count_down", int'(count_down), 0);
        chk("R10", "tc_pulse", int'(tc_pulse), 0);
        chk("R10", "ovf_flag", int'(ovf_flag), 0);
        chk("R10", "irq", int'(irq), 0);
        rst_n = 1'b1;
        step(1);
        cmp_on = 1'b1;

        // R1: divide by 8, 17 edges after start gives 2 steps
        mode_sel = 2'd0; div_sel = 3'd3; clr_stb = 1'b1;
        step(1);
        clr_stb = 1'b0; run_en = 1'b1;
        step(17);
        chk("R1", "count after 17 cycles at /8", int'(count), 2);

        // R2: stop holds
        run_en = 1'b0;
        step(20);
        chk("R2", "count while stopped", int'(count), 2);

        // R3: full speed up to 0xFF sets flag
        div_sel = 3'd0; run_en = 1'b1;
        step(254);
        chk("R3", "count at top", int'(count), 255);
        chk("R3", "flag at top", int'(ovf_flag), 1);

        // R9: mask raised after flag already set
        ovf_mask = 1'b1;
        #0;
        chk("R9", "irq after late mask", int'(irq), 1);
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        chk("R8", "flag after clear pulse", int'(ovf_flag), 0);
        chk("R9", "irq after clear", int'(irq), 0);

        // R7 then R6
        mode_sel = 2'd3; limit_val = 8'd4; clr_stb = 1'b1;
        step(1);
        clr_stb = 1'b0;
        chk("R7", "count after clear", int'(count), 0);
        chk("R7", "dir after clear", int'(count_down), 0);
        step(5);
        chk("R6", "count past turn", int'(count), 3);
        chk("R6", "dir past turn", int'(count_down), 1);
        step(3);
        chk("R6", "count back at zero", int'(count), 0);
        chk("R6", "dir back up", int'(count_down), 0);
        chk("R6", "tc at zero", int'(tc_pulse), 1);

        // R4: down mode load, run out, rest
        run_en = 1'b0;
        step(1);
        mode_sel = 2'd1; limit_val = 8'd5; run_en = 1'b1;
        step(1);
        chk("R4", "load value", int'(count), 5);
        chk("R4", "down dir", int'(count_down), 1);
        step(5);
        chk("R4", "reached zero", int'(count), 0);
        chk("R4", "tc on zero", int'(tc_pulse), 1);
        step(3);
        chk("R4", "rests at zero", int'(count), 0);

        // R5 and R8 same-cycle set and clear
        mode_sel = 2'd2; limit_val = 8'd2; clr_stb = 1'b1; ovf_clr = 1'b1;
        step(1);
        clr_stb = 1'b0; ovf_clr = 1'b0;
        chk("R8", "flag cleared", int'(ovf_flag), 0);
        step(2);
        chk("R5", "count at limit", int'(count), 2);
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        chk("R5", "wrap to zero", int'(count), 0);
        chk("R8", "set beats clear", int'(ovf_flag), 1);

        // constrained random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 100 < 3) run_en = ~run_en;
            clr_stb = ($urandom % 80 == 0);
            ovf_clr = ($urandom % 12 == 0);
            if ($urandom % 150 == 0) mode_sel = 2'($urandom % 4);
            if ($urandom % 300 == 0) begin
                int d;
                d = $urandom % 8;
                if (d > 3 && ($urandom % 2 == 0)) d = d % 4;
                div_sel = 3'(d);
            end
            if ($urandom % 100 == 0)
                limit_val = ($urandom % 6 == 0) ? 8'($urandom) : 8'($urandom % 12);
            if ($urandom % 40 == 0) ovf_mask = ~ovf_mask;
            step(1);
        end
        clr_stb = 1'b0; ovf_clr = 1'b0;
        step(2);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule